// File: doc/BRIEF.md
# Sparse Output-Stationary Tensor Array

This block multiplies an activation matrix by a weight matrix whose columns are stored in a bounded-density compressed form. Each compressed block covers `BZ` consecutive reduction positions and keeps only `nnz` weights per column, each with a position index inside the block. The array is a grid of `ROWS` x `COLS` tensor cells. Each cell owns a `TA` x `TC` tile of 32-bit accumulators, and each accumulator is fed by its own single multiplier. Each multiplier has a selector that picks, from the held activation block, the element named by the index of the weight it is processing.

Activation blocks enter at the left edge, one block per block period per row. A cell holds its block for a whole period and then hands it to its right neighbour. Compressed weight rows enter at the top edge, one row per clock. A cell passes each row to the cell below exactly one block period later. The block period is `nnz` cycles and is chosen at run time, so a sparser model finishes in fewer cycles on the same multipliers. Accumulators stay in place until the stream has drained. They are then shifted up row by row and read at the top.

Top module: `sta_array`

## Requirements
- R1: After reset every accumulator is zero, so `acc_out` reads all zeros.
- R2: A cycle with `clr` high zeroes every accumulator, invalidates all held operands and buffered weight rows, and makes the next cycle phase 0 of a block period. `clr` takes priority over `rd_shift`.
- R3: A block period lasts `nnz` cycles, for `nnz` from 1 to `BZ`. The compressed weight row `r` of a block is presented at the top edge in phase `r` of the period.
- R4: In each accumulating cycle, accumulator (a,c) of a cell adds the signed product of weight c of the current row and element `idx_c` of activation row a of the held block. The product is sign-extended and added with 32-bit two's-complement wrap.
- R5: A cell loads its activation block, with its valid flag, in phase 0 and uses it from that same cycle. It holds the block unchanged for the rest of the period, and its right neighbour loads that block at the next phase 0.
- R6: A weight row and its indices reach the cell below exactly one block period (`nnz` cycles) after they reached the cell above.
- R7: When row i of block k enters at period k+i and column j of block k enters at period k+j, every accumulator ends with the dense product of the activations and the decompressed weights, summed over all blocks. This holds for each `nnz` from 1 to `BZ` and across streams that are not separated by `clr`.
- R8: An accumulator changes only when both the cell's activation block and the weight row are marked valid. Operands with their valid flags low leave all results unchanged.
- R9: When the selected activation element or the weight is zero, the multiplier is gated and its accumulator keeps its value.
- R10: `acc_out` shows the tiles of cell row 0. Each cycle with `rd_shift` high moves every cell row's tiles up one row and loads zeros into the bottom row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Zero accumulators, flush operands, restart the block phase |
| nnz | input | $clog2(BZ+1) | Non-zero weights per block, 1..BZ |
| act_in | input | ROWS*TA*BZ*8 | Activation blocks; row i, tile row a, position p at bit ((i*TA+a)*BZ+p)*8 |
| act_vld | input | ROWS | Activation block valid per row, sampled in phase 0 |
| wgt_in | input | COLS*TC*8 | Compressed weight row; column j, lane c at bit (j*TC+c)*8 |
| wgt_idx | input | COLS*TC*$clog2(BZ) | Block position of each weight, same lane order |
| wgt_vld | input | COLS | Weight row valid per column |
| rd_shift | input | 1 | Shift accumulator tiles up one cell row |
| acc_out | output | COLS*TA*TC*32 | Cell row 0 tiles; column j, (a,c) at bit ((j*TA+a)*TC+c)*32 |

## Verification
The hardest case to reach from the ports is a cell away from both edges. There, an activation block that crossed several cells meets a weight row that waited in several delay lines. This happens with `nnz` below `BZ`, so the delay lines wrap at a runtime depth rather than at their full size. The bench drives the edges with the diagonal schedule of R7 for several `nnz` values and several block counts, so every cell depends on both skew paths. It also chains a second stream directly after a first, with no clear between them. The second stream carries either zero activations or invalid operands, which shows that later operands flowing through loaded cells do not disturb results already accumulated.

// File: rtl/sta_pkg.sv
package sta_pkg;

    // Last phase index of a block period for a requested non-zero count.
    function automatic int unsigned last_phase(input int unsigned nnz, input int unsigned bz);
        if (nnz == 0)
            return 0;
        else if (nnz > bz)
            return bz - 1;
        else
            return nnz - 1;
    endfunction

endpackage

// File: rtl/sta_phase.sv
module sta_phase #(
    parameter int BZ   = 8,
    parameter int NNZW = $clog2(BZ + 1),
    parameter int PHW  = $clog2(BZ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [NNZW-1:0] nnz,
    output logic [PHW-1:0]  ph,
    output logic            ph_first
);

    typedef struct packed {
        logic [PHW-1:0] ph;
    } st_t;

    st_t            q, d;
    logic [PHW-1:0] last;

    always_comb begin
        last = PHW'(sta_pkg::last_phase(32'(nnz), BZ));
        d    = q;
        if (clr)
            d.ph = '0;
        else if (q.ph >= last)
            d.ph = '0;
        else
            d.ph = q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign ph       = q.ph;
    assign ph_first = (q.ph == '0);

endmodule

// File: rtl/sta_wdly.sv
module sta_wdly #(
    parameter int BZ   = 8,
    parameter int TC   = 2,
    parameter int OPW  = 8,
    parameter int IDXW = $clog2(BZ),
    parameter int PHW  = $clog2(BZ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [PHW-1:0]     ph,
    input  logic [TC*OPW-1:0]  in_w,
    input  logic [TC*IDXW-1:0] in_ix,
    input  logic               in_v,
    output logic [TC*OPW-1:0]  out_w,
    output logic [TC*IDXW-1:0] out_ix,
    output logic               out_v
);

    typedef struct packed {
        logic               v;
        logic [TC*IDXW-1:0] ix;
        logic [TC*OPW-1:0]  w;
    } slot_t;

    typedef struct packed {
        slot_t [BZ-1:0] slot;
    } st_t;

    st_t q, d;

    // One slot per phase: the slot read in phase r was written in phase r
    // of the previous block period, giving a delay of exactly nnz cycles.
    always_comb begin
        d = q;
        if (clr) begin
            for (int k = 0; k < BZ; k++)
                d.slot[k].v = 1'b0;
        end else begin
            d.slot[ph] = slot_t'({in_v, in_ix, in_w});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign {out_v, out_ix, out_w} = q.slot[ph];

endmodule

// File: rtl/sta_tpe.sv
module sta_tpe #(
    parameter int TA   = 2,
    parameter int TC   = 2,
    parameter int BZ   = 8,
    parameter int OPW  = 8,
    parameter int ACCW = 32,
    parameter int IDXW = $clog2(BZ)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  ph_first,
    input  logic                  shift,
    input  logic [TA*BZ*OPW-1:0]  act_src,
    input  logic                  act_src_v,
    input  logic [TC*OPW-1:0]     w_row,
    input  logic [TC*IDXW-1:0]    w_idx,
    input  logic                  w_v,
    input  logic [TA*TC*ACCW-1:0] acc_in,
    output logic [TA*BZ*OPW-1:0]  act_hold,
    output logic                  act_hold_v,
    output logic [TA*TC*ACCW-1:0] acc_tile
);

    localparam int EXT = ACCW - 2 * OPW;

    typedef struct packed {
        logic                  v;
        logic [TA*BZ*OPW-1:0]  act;
        logic [TA*TC*ACCW-1:0] acc;
    } st_t;

    st_t                    q, d;
    logic [TA*BZ*OPW-1:0]   act_use;
    logic                   use_v;
    logic [IDXW-1:0]        ix;
    logic signed [OPW-1:0]  sa, sw;
    logic signed [2*OPW-1:0] pr;
    logic [ACCW-1:0]        ex;

    always_comb begin
        act_use = ph_first ? act_src : q.act;
        use_v   = ph_first ? act_src_v : q.v;
        ix      = '0;
        sa      = '0;
        sw      = '0;
        pr      = '0;
        ex      = '0;
        d       = q;
        if (clr) begin
            d.v   = 1'b0;
            d.acc = '0;
        end else begin
            if (ph_first) begin
                d.act = act_src;
                d.v   = act_src_v;
            end
            if (shift) begin
                d.acc = acc_in;
            end else begin
                for (int a = 0; a < TA; a++) begin
                    for (int c = 0; c < TC; c++) begin
                        ix = w_idx[c*IDXW +: IDXW];
                        sa = act_use[(a*BZ + int'(ix))*OPW +: OPW];
                        sw = w_row[c*OPW +: OPW];
                        pr = sa * sw;
                        ex = {{EXT{pr[2*OPW-1]}}, pr};
                        if (use_v && w_v && (sa != '0) && (sw != '0))
                            d.acc[(a*TC+c)*ACCW +: ACCW] = q.acc[(a*TC+c)*ACCW +: ACCW] + ex;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign act_hold   = q.act;
    assign act_hold_v = q.v;
    assign acc_tile   = q.acc;

endmodule

// File: rtl/sta_array.sv
module sta_array #(
    parameter int ROWS = 2,
    parameter int COLS = 2,
    parameter int TA   = 2,
    parameter int TC   = 2,
    parameter int BZ   = 8,
    parameter int OPW  = 8,
    parameter int ACCW = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic [$clog2(BZ+1)-1:0]          nnz,
    input  logic [ROWS*TA*BZ*OPW-1:0]        act_in,
    input  logic [ROWS-1:0]                  act_vld,
    input  logic [COLS*TC*OPW-1:0]           wgt_in,
    input  logic [COLS*TC*$clog2(BZ)-1:0]    wgt_idx,
    input  logic [COLS-1:0]                  wgt_vld,
    input  logic                             rd_shift,
    output logic [COLS*TA*TC*ACCW-1:0]       acc_out
);

    localparam int IDXW = $clog2(BZ);
    localparam int NNZW = $clog2(BZ + 1);
    localparam int PHW  = $clog2(BZ);
    localparam int ABLK = TA * BZ * OPW;
    localparam int WROW = TC * OPW;
    localparam int IROW = TC * IDXW;
    localparam int TILE = TA * TC * ACCW;

    logic [PHW-1:0]  ph;
    logic            ph_first;

    logic [ABLK-1:0] act_ch  [ROWS][COLS+1];
    logic            act_chv [ROWS][COLS+1];
    logic [WROW-1:0] w_ch    [ROWS][COLS];
    logic [IROW-1:0] i_ch    [ROWS][COLS];
    logic            v_ch    [ROWS][COLS];
    logic [TILE-1:0] tile    [ROWS+1][COLS];
    logic [COLS*TILE-1:0] acc_row_nxt;

    sta_phase #(.BZ(BZ), .NNZW(NNZW), .PHW(PHW)) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .nnz      (nnz),
        .ph       (ph),
        .ph_first (ph_first)
    );

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign act_ch[i][0]  = act_in[i*ABLK +: ABLK];
        assign act_chv[i][0] = act_vld[i];
        for (genvar j = 0; j < COLS; j++) begin : g_col
            if (i == 0) begin : g_top
                assign w_ch[0][j] = wgt_in[j*WROW +: WROW];
                assign i_ch[0][j] = wgt_idx[j*IROW +: IROW];
                assign v_ch[0][j] = wgt_vld[j];
            end
            if (i < ROWS - 1) begin : g_dly
                sta_wdly #(.BZ(BZ), .TC(TC), .OPW(OPW), .IDXW(IDXW), .PHW(PHW)) wdly_i (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .clr    (clr),
                    .ph     (ph),
                    .in_w   (w_ch[i][j]),
                    .in_ix  (i_ch[i][j]),
                    .in_v   (v_ch[i][j]),
                    .out_w  (w_ch[i+1][j]),
                    .out_ix (i_ch[i+1][j]),
                    .out_v  (v_ch[i+1][j])
                );
            end
            sta_tpe #(.TA(TA), .TC(TC), .BZ(BZ), .OPW(OPW), .ACCW(ACCW), .IDXW(IDXW)) tpe_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .clr        (clr),
                .ph_first   (ph_first),
                .shift      (rd_shift),
                .act_src    (act_ch[i][j]),
                .act_src_v  (act_chv[i][j]),
                .w_row      (w_ch[i][j]),
                .w_idx      (i_ch[i][j]),
                .w_v        (v_ch[i][j]),
                .acc_in     (tile[i+1][j]),
                .act_hold   (act_ch[i][j+1]),
                .act_hold_v (act_chv[i][j+1]),
                .acc_tile   (tile[i][j])
            );
        end
    end

    for (genvar j = 0; j < COLS; j++) begin : g_out
        assign tile[ROWS][j]               = '0;
        assign acc_out[j*TILE +: TILE]     = tile[0][j];
        assign acc_row_nxt[j*TILE +: TILE] = tile[1][j];
    end

endmodule

// File: rtl/sta_array_chk.sv
module sta_array_chk #(
    parameter int COLS = 2,
    parameter int TA   = 2,
    parameter int TC   = 2,
    parameter int BZ   = 8,
    parameter int OPW  = 8,
    parameter int ACCW = 32,
    parameter int NNZW = $clog2(BZ + 1),
    parameter int PHW  = $clog2(BZ)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        clr,
    input logic                        rd_shift,
    input logic [NNZW-1:0]             nnz,
    input logic [PHW-1:0]              ph,
    input logic [COLS*TA*TC*ACCW-1:0]  acc_out,
    input logic [COLS*TA*TC*ACCW-1:0]  acc_row1,
    input logic [TA*BZ*OPW-1:0]        hold00
);

    logic [PHW-1:0] last_c;

    always_comb last_c = PHW'(sta_pkg::last_phase(32'(nnz), BZ));

    assert_clr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_out == '0));

    assert_clr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ph == '0));

    assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (ph < last_c)) |=> (ph == $past(ph) + 1'b1));

    assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (ph >= last_c)) |=> (ph == '0));

    assert_act_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (ph != '0)) |=> $stable(hold00));

    assert_shift_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_shift && !clr) |=> (acc_out == $past(acc_row1)));

endmodule

bind sta_array sta_array_chk #(
    .COLS (COLS),
    .TA   (TA),
    .TC   (TC),
    .BZ   (BZ),
    .OPW  (OPW),
    .ACCW (ACCW),
    .NNZW (NNZW),
    .PHW  (PHW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .rd_shift (rd_shift),
    .nnz      (nnz),
    .ph       (ph),
    .acc_out  (acc_out),
    .acc_row1 (acc_row_nxt),
    .hold00   (act_ch[0][1])
);

// File: tb/sta_array_tb_top.sv
`timescale 1ns/1ps
module sta_array_tb_top;

    localparam int ROWS  = 2;
    localparam int COLS  = 2;
    localparam int TA    = 2;
    localparam int TC    = 2;
    localparam int BZ    = 8;
    localparam int OPW   = 8;
    localparam int ACCW  = 32;
    localparam int IDXW  = $clog2(BZ);
    localparam int NNZW  = $clog2(BZ + 1);
    localparam int KBMAX = 3;
    localparam int KMAX  = KBMAX * BZ;
    localparam int MR    = ROWS * TA;
    localparam int NC    = COLS * TC;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic                          clr = 1'b0;
    logic [NNZW-1:0]               nnz = NNZW'(BZ);
    logic [ROWS*TA*BZ*OPW-1:0]     act_in = '0;
    logic [ROWS-1:0]               act_vld = '0;
    logic [COLS*TC*OPW-1:0]        wgt_in = '0;
    logic [COLS*TC*IDXW-1:0]       wgt_idx = '0;
    logic [COLS-1:0]               wgt_vld = '0;
    logic                          rd_shift = 1'b0;
    logic [COLS*TA*TC*ACCW-1:0]    acc_out;

    int am [MR][KMAX];
    int cw [NC][KBMAX][BZ];
    int ci [NC][KBMAX][BZ];
    int wd [KMAX][NC];
    int expm [MR][NC];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sta_array #(.ROWS(ROWS), .COLS(COLS), .TA(TA), .TC(TC), .BZ(BZ), .OPW(OPW), .ACCW(ACCW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .nnz      (nnz),
        .act_in   (act_in),
        .act_vld  (act_vld),
        .wgt_in   (wgt_in),
        .wgt_idx  (wgt_idx),
        .wgt_vld  (wgt_vld),
        .rd_shift (rd_shift),
        .acc_out  (acc_out)
    );

    function automatic int hv(input int s, input int k);
        return ((s * 131 + k * 71 + s * k * 13 + 17) % 256) - 128;
    endfunction

    task automatic check_val(input string req, input int got, input int want);
        checks++;
        if (got != want) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, got, want);
        end
    endtask

    // mode 0: normal data, 1: zero activations, 2: operands invalid, 3: most negative values
    task automatic build(input int nz, input int kb, input int seed, input int mode);
        for (int k = 0; k < KMAX; k++)
            for (int n = 0; n < NC; n++)
                wd[k][n] = 0;
        for (int r = 0; r < MR; r++)
            for (int k = 0; k < KMAX; k++) begin
                if (mode == 1) am[r][k] = 0;
                else if (mode == 3) am[r][k] = -128;
                else if ((r + k + seed) % 7 == 0) am[r][k] = 0;
                else am[r][k] = hv(seed + r, k);
            end
        for (int n = 0; n < NC; n++)
            for (int b = 0; b < kb; b++) begin
                int base;
                base = (seed + n * 3 + b) % BZ;
                for (int r = 0; r < nz; r++) begin
                    int ix, val;
                    ix  = (base + r * 3) % BZ;
                    val = (mode == 3) ? -128 : hv(seed * 5 + n, b * BZ + r + 40);
                    if (mode == 0 && (n + r + seed) % 5 == 0) val = 0;
                    cw[n][b][r] = val;
                    ci[n][b][r] = ix;
                    wd[b * BZ + ix][n] = val;
                end
            end
        if (mode == 0 || mode == 3)
            for (int r = 0; r < MR; r++)
                for (int n = 0; n < NC; n++)
                    for (int k = 0; k < kb * BZ; k++)
                        expm[r][n] += am[r][k] * wd[k][n];
    endtask

    task automatic drive_idle();
        act_in  = '0;
        act_vld = '0;
        wgt_in  = '0;
        wgt_idx = '0;
        wgt_vld = '0;
    endtask

    task automatic drive(input int p, input int r, input int kb, input int mode);
        drive_idle();
        for (int i = 0; i < ROWS; i++) begin
            int k;
            k = p - i;
            if (k >= 0 && k < kb) begin
                act_vld[i] = (mode != 2);
                for (int a = 0; a < TA; a++)
                    for (int pos = 0; pos < BZ; pos++)
                        act_in[((i*TA+a)*BZ+pos)*OPW +: OPW] = OPW'(am[i*TA+a][k*BZ+pos]);
            end
        end
        for (int j = 0; j < COLS; j++) begin
            int k;
            k = p - j;
            if (k >= 0 && k < kb) begin
                wgt_vld[j] = (mode != 2);
                for (int c = 0; c < TC; c++) begin
                    wgt_in[(j*TC+c)*OPW +: OPW]    = OPW'(cw[j*TC+c][k][r]);
                    wgt_idx[(j*TC+c)*IDXW +: IDXW] = IDXW'(ci[j*TC+c][k][r]);
                end
            end
        end
    endtask

    task automatic stream(input int nz, input int kb, input int seed, input int mode, input bit do_clr);
        build(nz, kb, seed, mode);
        if (do_clr) begin
            @(negedge clk);
            drive_idle();
            clr = 1'b1;
            nnz = NNZW'(nz);
        end
        for (int p = 0; p < kb + ROWS + COLS - 2; p++)
            for (int r = 0; r < nz; r++) begin
                @(negedge clk);
                clr = 1'b0;
                drive(p, r, kb, mode);
            end
    endtask

    task automatic readout(input string req);
        @(negedge clk);
        drive_idle();
        for (int i = 0; i < ROWS; i++) begin
            for (int j = 0; j < COLS; j++)
                for (int a = 0; a < TA; a++)
                    for (int c = 0; c < TC; c++)
                        check_val(req, $signed(acc_out[((j*TA+a)*TC+c)*ACCW +: ACCW]),
                                  expm[i*TA+a][j*TC+c]);
            rd_shift = 1'b1;
            @(negedge clk);
            rd_shift = 1'b0;
        end
        // R10: after every row has been shifted out, zeros have filled the array
        for (int e = 0; e < COLS * TA * TC; e++)
            check_val("R10 zero fill", $signed(acc_out[e*ACCW +: ACCW]), 0);
        for (int r = 0; r < MR; r++)
            for (int n = 0; n < NC; n++)
                expm[r][n] = 0;
    endtask

    task automatic t_reset();
        for (int e = 0; e < COLS * TA * TC; e++)
            check_val("R1 reset", $signed(acc_out[e*ACCW +: ACCW]), 0);
    endtask

    task automatic t_dense();
        stream(8, 2, 3, 0, 1'b1);
        readout("R3 R4 R5 R6 R7 nnz=8");
    endtask

    task automatic t_half();
        stream(4, 3, 11, 0, 1'b1);
        readout("R5 R6 R7 nnz=4");
    endtask

    task automatic t_single();
        stream(1, 3, 21, 0, 1'b1);
        readout("R3 R7 nnz=1");
    endtask

    task automatic t_odd();
        stream(3, 2, 5, 0, 1'b1);
        readout("R3 R6 R7 nnz=3");
    endtask

    task automatic t_extreme();
        stream(8, 2, 0, 3, 1'b1);
        readout("R4 signed extreme");
    endtask

    task automatic t_chain();
        stream(2, 2, 4, 0, 1'b1);
        stream(2, 1, 8, 0, 1'b0);
        readout("R7 chained streams");
    endtask

    task automatic t_zero_act();
        stream(4, 2, 9, 0, 1'b1);
        stream(4, 2, 13, 1, 1'b0);
        readout("R9 zero activations");
    endtask

    task automatic t_invalid();
        stream(4, 2, 9, 0, 1'b1);
        stream(4, 2, 13, 2, 1'b0);
        readout("R8 invalid operands");
    endtask

    task automatic t_clear();
        stream(4, 2, 7, 0, 1'b1);
        @(negedge clk);
        drive_idle();
        clr = 1'b1;
        rd_shift = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        rd_shift = 1'b0;
        for (int r = 0; r < MR; r++)
            for (int n = 0; n < NC; n++)
                expm[r][n] = 0;
        readout("R2 clear");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < MR; r++)
            for (int n = 0; n < NC; n++)
                expm[r][n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dense();
        t_half();
        t_single();
        t_odd();
        t_extreme();
        t_chain();
        t_zero_act();
        t_invalid();
        t_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule